// File: doc/BRIEF.md
# Serial Memory Read Command Engine

This block is the device-side controller of a bit-serial memory read. A bus master sends three bytes, one bit per write slot: a command byte, the low byte of a start address and the high byte. When the command is the read code and the address lies inside the 128-byte array, the engine answers every following read slot with the next data bit. It walks from the start byte up to the last byte of the array. When the final byte has gone out, a 16-bit check value follows, and after that the line reads high.

The check value covers the whole transaction: the command, both address bytes and every data byte returned. A bus reset clears everything at any point. A read cut short by a bus reset never yields a check value. The next bus reset begins a new transaction. The array is filled through a plain write port before a transaction starts.

Top module: `smr_read_engine`

## Requirements
- R1: After `rst` or a `bus_reset`, the engine waits for a command byte, and `rd_bit` reads 1 until data is due.
- R2: The master sends three bytes over write slots: the command, then address bits 7..0, then address bits 15..8. Each byte is sent least significant bit first.
- R3: The command code 0xF0 starts a read. Any other code makes every read slot return 1 until the next bus reset.
- R4: A start address whose bits 15..8 are not all zero, or whose bit 7 is set, makes every read slot return 1 until the next bus reset.
- R5: With a valid start address A, read slots return the bytes at A, A+1, ... up to address 127, each byte least significant bit first.
- R6: The check value is a CRC. It is cleared to 0 when a transaction starts and is updated bit-serially with the reflected form 0xA001 of the polynomial x^16+x^15+x^2+1. It is fed the command bits, the address bits and every data bit sent. After byte 127, the next 16 read slots return the complement of this CRC, bit 0 first.
- R7: After the 16 CRC bits, every read slot returns 1 until a bus reset.
- R8: A `bus_reset` during any phase aborts the transaction and no CRC is produced for it. The next transaction's CRC covers only its own bytes.
- R9: `rd_bit` is valid in the same cycle as `rd_slot`. Slot strobes never overlap and start at least 3 cycles apart; this spacing also holds between the last address bit and the first read slot. `rd_bit` changes only in answer to a read slot, a reset, or the first data fetch.
- R10: When `ld_en` is high, `ld_data` is written at `ld_addr`, and later reads return the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset; aborts and restarts the transaction |
| wr_slot | input | 1 | Write-slot strobe, one bit from the master |
| wr_bit | input | 1 | Bit carried by the write slot |
| rd_slot | input | 1 | Read-slot strobe |
| rd_bit | output | 1 | Registered bit answering the current read slot |
| ld_en | input | 1 | Array load enable |
| ld_addr | input | 7 | Array load address |
| ld_data | input | 8 | Array load data |

## Verification
When the last address bit arrives at edge E0, the first data byte reaches the output register at edge E2. Each later bit moves on the edge of its read slot, so it is valid for the next slot, three cycles on. The bench drives every slot with the minimum spacing: one strobe cycle and two idle cycles. This puts the first read slot right at the earliest point the R9 timing allows. It samples `rd_bit` a quarter period after driving the strobe, before the edge the strobe acts on. The driver computes the expected bit for each slot from its own array model and CRC function and queues it. The monitor compares each sampled bit in slot order, so the check for every bit sits on its due cycle.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ALO, ST_AHI, ST_FETCH, ST_DATA, ST_CRC, ST_ONES, ST_HALT
  } smr_state_t;
endpackage

// File: rtl/smr_mem.sv
module smr_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smr_crc.sv
module smr_crc #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = 16'hA001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc,
  output logic [W-1:0] crc_nxt
);
  logic fb;

  always_comb begin
    fb      = crc[0] ^ din;
    crc_nxt = crc;
    if (en) crc_nxt = (crc >> 1) ^ (fb ? POLY[W-1:0] : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else            crc <= crc_nxt;
  end
endmodule

// File: rtl/smr_read_engine.sv
module smr_read_engine
  import smr_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          DW       = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [7:0]  CMD_READ = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_reset,
  input  logic          wr_slot,
  input  logic          wr_bit,
  input  logic          rd_slot,
  output logic          rd_bit,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data
);
  localparam int            BC_W    = $clog2(DW);
  localparam int            CC_W    = $clog2(CRC_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DW - 1);
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CRC_W - 1);
  localparam logic [AW-1:0]   A_LAST  = '1;

  smr_state_t     state;
  logic [BC_W-1:0] bcnt;
  logic [CC_W-1:0] ccnt;
  logic [DW-1:0]  in_sr, addr_lo, sh, ram_q, in_byte;
  logic [AW-1:0]  ptr;
  logic [CRC_W-1:0] crc_sr, crc_val, crc_nxt;
  logic           cur_last, fetch_wait, out_q;
  logic           in_hdr, crc_en, crc_din;

  assign in_hdr  = (state == ST_CMD) || (state == ST_ALO) || (state == ST_AHI);
  assign crc_en  = (wr_slot && in_hdr) || (rd_slot && state == ST_DATA);
  assign crc_din = in_hdr ? wr_bit : out_q;
  assign in_byte = {wr_bit, in_sr[DW-1:1]};
  assign rd_bit  = out_q;

  smr_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .raddr(ptr), .rdata(ram_q)
  );

  smr_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(bus_reset), .en(crc_en), .din(crc_din),
    .crc(crc_val), .crc_nxt(crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      state      <= ST_CMD;
      bcnt       <= '0;
      ccnt       <= '0;
      in_sr      <= '0;
      addr_lo    <= '0;
      sh         <= '0;
      ptr        <= '0;
      crc_sr     <= '0;
      cur_last   <= 1'b0;
      fetch_wait <= 1'b0;
      out_q      <= 1'b1;
    end else begin
      case (state)
        ST_CMD, ST_ALO, ST_AHI: begin
          if (wr_slot) begin
            in_sr <= in_byte;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == BC_LAST) begin
              bcnt <= '0;
              if (state == ST_CMD) begin
                state <= (in_byte == CMD_READ) ? ST_ALO : ST_HALT;
              end else if (state == ST_ALO) begin
                addr_lo <= in_byte;
                state   <= ST_AHI;
              end else if ((in_byte != '0) || (addr_lo[DW-1:AW] != '0)) begin
                state <= ST_ONES;
              end else begin
                ptr        <= addr_lo[AW-1:0];
                fetch_wait <= 1'b1;
                state      <= ST_FETCH;
              end
            end
          end
        end
        ST_FETCH: begin
          if (fetch_wait) begin
            fetch_wait <= 1'b0;
          end else begin
            sh       <= ram_q;
            out_q    <= ram_q[0];
            cur_last <= (ptr == A_LAST);
            ptr      <= ptr + 1'b1;
            bcnt     <= '0;
            state    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rd_slot) begin
            if (bcnt == BC_LAST) begin
              bcnt <= '0;
              if (cur_last) begin
                crc_sr <= ~crc_nxt;
                out_q  <= ~crc_nxt[0];
                ccnt   <= '0;
                state  <= ST_CRC;
              end else begin
                sh       <= ram_q;
                out_q    <= ram_q[0];
                cur_last <= (ptr == A_LAST);
                ptr      <= ptr + 1'b1;
              end
            end else begin
              sh    <= sh >> 1;
              out_q <= sh[1];
              bcnt  <= bcnt + 1'b1;
            end
          end
        end
        ST_CRC: begin
          if (rd_slot) begin
            if (ccnt == CC_LAST) begin
              out_q <= 1'b1;
              state <= ST_ONES;
            end else begin
              crc_sr <= crc_sr >> 1;
              out_q  <= crc_sr[1];
              ccnt   <= ccnt + 1'b1;
            end
          end
        end
        default: out_q <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/smr_read_engine_chk.sv
module smr_read_engine_chk
  import smr_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_reset,
  input logic             wr_slot,
  input logic             rd_slot,
  input logic             rd_bit,
  input smr_state_t       state,
  input logic [CRC_W-1:0] crc
);
  // R8: a bus reset returns to the command phase with the line high
  p_abort_high_r8: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (rd_bit && state == ST_CMD));

  // R6: the CRC starts from zero for every new transaction
  p_crc_clear_r6: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (crc == '0));

  // R1: no data bit leaves while the header is still arriving
  p_hdr_high_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD || state == ST_ALO || state == ST_AHI) |-> rd_bit);

  // R3: a rejected command keeps the line high
  p_halt_high_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT) |-> rd_bit);

  // R7: the tail after the CRC (and a bad address, R4) reads high
  p_tail_high_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ONES) |-> rd_bit);

  // R9: the output moves only in answer to a read slot
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_slot && !bus_reset &&
     (state == ST_DATA || state == ST_CRC || state == ST_ONES || state == ST_HALT))
    |=> $stable(rd_bit));

  // R9: strobes never overlap
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_slot && rd_slot));
endmodule

bind smr_read_engine smr_read_engine_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .wr_slot(wr_slot),
  .rd_slot(rd_slot), .rd_bit(rd_bit), .state(state), .crc(crc_val)
);

// File: tb/smr_read_engine_bench.sv
module smr_read_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, bus_reset = 1'b0;
  logic wr_slot = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0, ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic rd_bit;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];
  bit    exp_q[$];
  string tag_q[$];
  event  mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  smr_read_engine u_smr_read_engine (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .wr_slot(wr_slot),
    .wr_bit(wr_bit), .rd_slot(rd_slot), .rd_bit(rd_bit),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ v[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_bit=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: compare each sampled read bit against the scoreboard
  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL R9: unexpected read slot, rd_bit=%0b expected=none", rd_bit);
    end else begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_bit, e, t);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk); wr_slot = 1'b1; wr_bit = b;
    @(negedge clk); wr_slot = 1'b0;
    idle(1);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot();
    @(negedge clk); rd_slot = 1'b1;
    #(CLK_PERIOD/4);
    ->mon_ev;
    @(negedge clk); rd_slot = 1'b0;
    idle(1);
  endtask

  task automatic bus_pulse();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic load_mem(int mul, int add);
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'(i * mul + add);
      @(negedge clk); ld_en = 1'b1; ld_addr = AW'(i); ld_data = model[i];
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  // driver: send the header, queue the expected bits, then issue the reads
  task automatic run_txn(logic [7:0] cmd, logic [7:0] lo, logic [7:0] hi,
                         int nreads, string dtag);
    bit    eb[$];
    string et[$];
    logic [15:0] c;
    bit ok;
    ok = (cmd == 8'hF0) && (hi == 8'h00) && (lo[7] == 1'b0);
    if (ok) begin
      c = crc_byte(16'h0, cmd);
      c = crc_byte(c, lo);
      c = crc_byte(c, hi);
      for (int a = int'(lo); a < DEPTH; a++) begin
        for (int i = 0; i < 8; i++) begin
          eb.push_back(model[a][i]);
          et.push_back((eb.size() == 1) ? "R9" : dtag);
        end
        c = crc_byte(c, model[a]);
      end
      for (int i = 0; i < 16; i++) begin
        eb.push_back(~c[i]);
        et.push_back("R6");
      end
    end
    send_byte(cmd);
    send_byte(lo);
    send_byte(hi);
    for (int k = 0; k < nreads; k++) begin
      if (k < eb.size()) begin
        exp_q.push_back(eb[k]); tag_q.push_back(et[k]);
      end else begin
        exp_q.push_back(1'b1);
        tag_q.push_back(!ok ? ((cmd != 8'hF0) ? "R3" : "R4") : "R7");
      end
      read_slot();
    end
  endtask

  initial begin
    load_mem(37, 11);
    idle(2);
    rst = 1'b0;
    idle(1);
    chk(rd_bit, 1'b1, "R1");                         // reset state
    run_txn(8'hF0, 8'd120, 8'h00, 64 + 16 + 8, "R5"); // tail of array + CRC + ones
    bus_pulse();
    chk(rd_bit, 1'b1, "R1");
    run_txn(8'hF0, 8'd0, 8'h00, 1024 + 16 + 4, "R2"); // whole array
    bus_pulse();
    run_txn(8'hF0, 8'd127, 8'h00, 8 + 16 + 4, "R5");  // single last byte
    bus_pulse();
    run_txn(8'h0F, 8'd0, 8'h00, 12, "R3");            // wrong command
    bus_pulse();
    run_txn(8'hF1, 8'd3, 8'h00, 12, "R3");
    bus_pulse();
    run_txn(8'hF0, 8'd4, 8'h01, 12, "R4");            // high address byte set
    bus_pulse();
    run_txn(8'hF0, 8'h80, 8'h00, 12, "R4");           // bit 7 set
    bus_pulse();
    run_txn(8'hF0, 8'd5, 8'h00, 20, "R8");            // aborted mid data
    bus_pulse();
    chk(rd_bit, 1'b1, "R8");
    run_txn(8'hF0, 8'd126, 8'h00, 16 + 16 + 4, "R8");
    bus_pulse();
    send_byte(8'hF0); send_byte(8'd9);                // aborted mid header
    bus_pulse();
    run_txn(8'hF0, 8'd125, 8'h00, 24 + 16 + 2, "R8");
    bus_pulse();
    load_mem(91, 200);                                // new contents
    bus_pulse();
    run_txn(8'hF0, 8'd118, 8'h00, 80 + 16 + 2, "R10");
    idle(4);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9: %0d expected bits never read, expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule